// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between the host write bus of a 128K x 16 flash memory and the array controller. It samples bus write cycles synchronously. A write is qualified by chip-enable, write-enable, output-enable and a power-good input. Each qualified write is fed into a sequencer that recognises the fixed address/data unlock handshakes. For every complete command, the block emits a single-cycle operation strobe: whole-chip erase, region erase with a region mask, word program with its target address and data, boot-region protection, and product-identification entry and exit.

A sticky protection flag, cleared only by reset, covers the lowest 8K words of the array. While the flag is clear, a main-array region erase also includes the boot region. Once the flag is set, that erase covers the main array alone, and any program aimed at the boot region is silently discarded. The array, its timing, status polling and supply sensing live elsewhere. The controller only consumes the strobes.

Top module: `flash_cmd_decoder`

## Requirements
- R1: Command recognition uses only write-data bits 7..0. Bits 15..8 never change which command is decoded. The program strobe carries all 16 data bits of the fourth cycle.
- R2: Every unlock step compares address bits 14..0 only. The first step is 0xAA written to 0x5555 and the second is 0x55 written to 0x2AAA. Address bits 16..15 are don't-care in these steps.
- R3: Word program is unlock, unlock, 0xA0 to 0x5555, and then any write. The fourth write raises `program_o` for one cycle. `program_addr_o`/`program_data_o` hold that write's address and data.
- R4: Chip erase is unlock, unlock, 0x80 to 0x5555, unlock, unlock, and then 0x10 to 0x5555. It raises `chip_erase_o` for one cycle.
- R5: Region erase uses the same five opening writes, followed by 0x30 to any address. Address bits 16..12 select the region: 0x03 selects parameter block 1 (mask bit 1), 0x05 selects parameter block 2 (mask bit 2), and 0x1F selects the main array (mask bit 3). Mask bit 0 is the boot region. Any other region code produces no strobe. `erase_mask_o` is zero whenever `sector_erase_o` is low.
- R6: The same five opening writes followed by 0x40 to 0x5555 raise `lockout_o` for one cycle. They also set `boot_locked_o` in the same cycle. The flag then stays set until reset.
- R7: A main-array region erase sets mask bit 0 as well when `boot_locked_o` is low. When the flag is set, the mask is 0x8.
- R8: While `boot_locked_o` is set, a program whose address is below 0x02000 produces no strobe. Programs at higher addresses still complete.
- R9: Unlock, unlock, then 0x90 to 0x5555 raises `id_enter_o`. Unlock, unlock, then 0xF0 to 0x5555 raises `id_exit_o`. So does a single 0xF0 write to any address while no sequence is in progress.
- R10: A write that does not match the expected next step returns the sequencer to idle and produces no strobe.
- R11: A write is not accepted while `bus_oe_n` is low, `bus_ce_n` is high, `bus_we_n` is high or `pwr_ok` is low. Such a write leaves the sequence position unchanged.
- R12: A write is accepted once, on the first clock edge at which all qualifying conditions hold. Holding them longer adds no further writes. Strobes appear in the cycle after that edge, last exactly one cycle, and at most one is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_ce_n | input | 1 | Chip enable, active low |
| bus_we_n | input | 1 | Write enable, active low |
| bus_oe_n | input | 1 | Output enable, active low; low inhibits writes |
| pwr_ok | input | 1 | Supply good; low inhibits writes |
| bus_addr | input | 17 | Word address of the bus cycle |
| bus_data | input | 16 | Write data of the bus cycle |
| chip_erase_o | output | 1 | Whole-array erase strobe |
| sector_erase_o | output | 1 | Region erase strobe |
| erase_mask_o | output | 4 | Regions to erase: bit0 boot, bit1 param 1, bit2 param 2, bit3 main |
| program_o | output | 1 | Word program strobe |
| program_addr_o | output | 17 | Address of the last issued program |
| program_data_o | output | 16 | Data of the last issued program |
| lockout_o | output | 1 | Boot protection command strobe |
| id_enter_o | output | 1 | Product-ID mode entry strobe |
| id_exit_o | output | 1 | Product-ID mode exit strobe |
| boot_locked_o | output | 1 | Sticky boot protection flag |

## Verification
Two functions can meet in one bus cycle: the final write of a command and an inhibit condition. The bench provokes this by holding output-enable low during the fourth write of a program sequence. It judges that no strobe appears and that the next clean write still completes the same program with its own address and data. It also covers the cycle in which the protection command fires. There it checks that `lockout_o` and `boot_locked_o` rise together, and that the very next region erase and boot-area program already see the flag.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    localparam int          CMD_W    = 8;
    localparam int          UNLK_W   = 15;
    localparam logic [14:0] UNLK_A1  = 15'h5555;
    localparam logic [14:0] UNLK_A2  = 15'h2AAA;

    localparam logic [7:0]  K_KEY1   = 8'hAA;
    localparam logic [7:0]  K_KEY2   = 8'h55;
    localparam logic [7:0]  K_PROG   = 8'hA0;
    localparam logic [7:0]  K_ERASE  = 8'h80;
    localparam logic [7:0]  K_CHIP   = 8'h10;
    localparam logic [7:0]  K_SECT   = 8'h30;
    localparam logic [7:0]  K_LOCK   = 8'h40;
    localparam logic [7:0]  K_IDIN   = 8'h90;
    localparam logic [7:0]  K_IDOUT  = 8'hF0;

    localparam logic [4:0]  RGN_P1   = 5'h03;
    localparam logic [4:0]  RGN_P2   = 5'h05;
    localparam logic [4:0]  RGN_MAIN = 5'h1F;

    localparam int MB_BOOT = 0;
    localparam int MB_P1   = 1;
    localparam int MB_P2   = 2;
    localparam int MB_MAIN = 3;

    typedef enum logic [2:0] {
        ST_IDLE, ST_KEY1, ST_KEY2, ST_PROG, ST_ERA, ST_ERA_KEY1, ST_ERA_KEY2
    } seq_st_e;

    typedef enum logic [2:0] {
        OP_NONE, OP_CHIP, OP_SECT, OP_PROG, OP_LOCK, OP_IDIN, OP_IDOUT
    } op_e;

    typedef struct packed {
        logic       chip;
        logic       sect;
        logic       prog;
        logic       lock;
        logic       idin;
        logic       idout;
        logic [3:0] mask;
    } fcd_evt_t;

endpackage

// File: rtl/fcd_wr_qual.sv
module fcd_wr_qual (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n_i,
    input  logic we_n_i,
    input  logic oe_n_i,
    input  logic pwr_ok_i,
    output logic wr_o
);
    typedef struct packed {
        logic prev;
    } qual_regs_t;

    qual_regs_t q_d, q_q;
    logic       active;

    always_comb begin
        active   = pwr_ok_i && !ce_n_i && !we_n_i && oe_n_i;
        q_d.prev = active;
        wr_o     = active && !q_q.prev;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    // R12
    single_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_o |=> !wr_o);

endmodule

// File: rtl/fcd_seq.sv
module fcd_seq
    import fcd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [UNLK_W-1:0] addr_lo_i,
    input  logic [CMD_W-1:0]  cmd_i,
    output op_e               op_o
);
    typedef struct packed {
        seq_st_e st;
    } seq_regs_t;

    seq_regs_t s_d, s_q;
    logic      hit1, hit2;

    always_comb begin
        hit1 = (addr_lo_i == UNLK_A1);
        hit2 = (addr_lo_i == UNLK_A2);
        s_d  = s_q;
        op_o = OP_NONE;
        if (wr_i) begin
            s_d.st = ST_IDLE;
            unique case (s_q.st)
                ST_IDLE: begin
                    if (hit1 && cmd_i == K_KEY1) s_d.st = ST_KEY1;
                    else if (cmd_i == K_IDOUT)   op_o   = OP_IDOUT;
                end
                ST_KEY1: if (hit2 && cmd_i == K_KEY2) s_d.st = ST_KEY2;
                ST_KEY2: begin
                    if (hit1) begin
                        unique case (cmd_i)
                            K_PROG:  s_d.st = ST_PROG;
                            K_ERASE: s_d.st = ST_ERA;
                            K_IDIN:  op_o   = OP_IDIN;
                            K_IDOUT: op_o   = OP_IDOUT;
                            default: ;
                        endcase
                    end
                end
                ST_PROG:     op_o = OP_PROG;
                ST_ERA:      if (hit1 && cmd_i == K_KEY1) s_d.st = ST_ERA_KEY1;
                ST_ERA_KEY1: if (hit2 && cmd_i == K_KEY2) s_d.st = ST_ERA_KEY2;
                ST_ERA_KEY2: begin
                    if (cmd_i == K_SECT)              op_o = OP_SECT;
                    else if (hit1 && cmd_i == K_CHIP) op_o = OP_CHIP;
                    else if (hit1 && cmd_i == K_LOCK) op_o = OP_LOCK;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{st: ST_IDLE};
        else        s_q <= s_d;
    end

    // R11
    hold_when_idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> s_q.st == $past(s_q.st));

    // R10
    op_returns_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_o != OP_NONE) |=> s_q.st == ST_IDLE);

endmodule

// File: rtl/fcd_guard.sv
module fcd_guard
    import fcd_pkg::*;
#(
    parameter int RGN_W     = 5,
    parameter int BOOT_SKIP = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  op_e              op_i,
    input  logic [RGN_W-1:0] rgn_i,
    output fcd_evt_t         ev_o,
    output logic             locked_o
);
    typedef struct packed {
        logic locked;
    } guard_regs_t;

    guard_regs_t g_d, g_q;
    logic        in_boot;

    always_comb begin
        in_boot = (rgn_i[RGN_W-1:BOOT_SKIP] == '0);
        g_d     = g_q;
        ev_o    = '0;
        unique case (op_i)
            OP_CHIP: ev_o.chip = 1'b1;
            OP_SECT: begin
                if (rgn_i == RGN_W'(RGN_P1))      ev_o.mask[MB_P1] = 1'b1;
                else if (rgn_i == RGN_W'(RGN_P2)) ev_o.mask[MB_P2] = 1'b1;
                else if (rgn_i == RGN_W'(RGN_MAIN)) begin
                    ev_o.mask[MB_MAIN] = 1'b1;
                    ev_o.mask[MB_BOOT] = !g_q.locked;
                end
                ev_o.sect = |ev_o.mask;
            end
            OP_PROG: ev_o.prog = !(g_q.locked && in_boot);
            OP_LOCK: begin
                ev_o.lock    = 1'b1;
                g_d.locked   = 1'b1;
            end
            OP_IDIN:  ev_o.idin  = 1'b1;
            OP_IDOUT: ev_o.idout = 1'b1;
            default: ;
        endcase
        locked_o = g_q.locked;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    // R6
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        g_q.locked |=> g_q.locked);

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int ADDR_W     = 17,
    parameter int DATA_W     = 16,
    parameter int REGION_LSB = 12,
    parameter int BOOT_WORDS = 8192
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_ce_n,
    input  logic              bus_we_n,
    input  logic              bus_oe_n,
    input  logic              pwr_ok,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    output logic              chip_erase_o,
    output logic              sector_erase_o,
    output logic [3:0]        erase_mask_o,
    output logic              program_o,
    output logic [ADDR_W-1:0] program_addr_o,
    output logic [DATA_W-1:0] program_data_o,
    output logic              lockout_o,
    output logic              id_enter_o,
    output logic              id_exit_o,
    output logic              boot_locked_o
);
    localparam int RGN_W     = ADDR_W - REGION_LSB;
    localparam int BOOT_LSB  = $clog2(BOOT_WORDS);
    localparam int BOOT_SKIP = BOOT_LSB - REGION_LSB;

    typedef struct packed {
        fcd_evt_t          ev;
        logic [ADDR_W-1:0] pa;
        logic [DATA_W-1:0] pd;
    } out_regs_t;

    out_regs_t r_d, r_q;
    logic      wr;
    op_e       op;
    fcd_evt_t  ev;
    logic      locked;

    fcd_wr_qual u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n_i   (bus_ce_n),
        .we_n_i   (bus_we_n),
        .oe_n_i   (bus_oe_n),
        .pwr_ok_i (pwr_ok),
        .wr_o     (wr)
    );

    fcd_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (wr),
        .addr_lo_i (bus_addr[UNLK_W-1:0]),
        .cmd_i     (bus_data[CMD_W-1:0]),
        .op_o      (op)
    );

    fcd_guard #(
        .RGN_W     (RGN_W),
        .BOOT_SKIP (BOOT_SKIP)
    ) u_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_i     (op),
        .rgn_i    (bus_addr[ADDR_W-1:REGION_LSB]),
        .ev_o     (ev),
        .locked_o (locked)
    );

    always_comb begin
        r_d    = r_q;
        r_d.ev = ev;
        if (ev.prog) begin
            r_d.pa = bus_addr;
            r_d.pd = bus_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign chip_erase_o   = r_q.ev.chip;
    assign sector_erase_o = r_q.ev.sect;
    assign erase_mask_o   = r_q.ev.mask;
    assign program_o      = r_q.ev.prog;
    assign program_addr_o = r_q.pa;
    assign program_data_o = r_q.pd;
    assign lockout_o      = r_q.ev.lock;
    assign id_enter_o     = r_q.ev.idin;
    assign id_exit_o      = r_q.ev.idout;
    assign boot_locked_o  = locked;

    // R12
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({chip_erase_o, sector_erase_o, program_o, lockout_o, id_enter_o, id_exit_o}));

    // R12
    prog_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        program_o |=> !program_o);

    // R8
    boot_prog_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        program_o |-> !(boot_locked_o && program_addr_o[ADDR_W-1:BOOT_LSB] == '0));

    // R7
    locked_main_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sector_erase_o && boot_locked_o) |-> !erase_mask_o[MB_BOOT]);

    // R7
    open_main_with_boot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sector_erase_o && !boot_locked_o && erase_mask_o[MB_MAIN]) |-> erase_mask_o[MB_BOOT]);

    // R5
    mask_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sector_erase_o |-> erase_mask_o == 4'h0);

    // R6
    lock_rise_with_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(boot_locked_o) |-> lockout_o);

endmodule

// File: tb/flash_cmd_decoder_test.sv
module flash_cmd_decoder_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV         = 63;

    typedef struct packed {
        logic [16:0] a;
        logic [15:0] d;
        logic [2:0]  code;
        logic [3:0]  mask;
        logic        lk;
        logic [3:0]  rq;
    } vec_t;

    // code: 0 none, 1 chip erase, 2 region erase, 3 program, 4 lockout, 5 id enter, 6 id exit
    localparam vec_t VEC [NV] = '{
        // R1 R3: program with high data byte set during unlock
        '{17'h05555, 16'hFFAA, 3'd0, 4'h0, 1'b0, 4'd1},
        '{17'h02AAA, 16'h0055, 3'd0, 4'h0, 1'b0, 4'd3},
        '{17'h05555, 16'h00A0, 3'd0, 4'h0, 1'b0, 4'd3},
        '{17'h00100, 16'h1234, 3'd3, 4'h0, 1'b0, 4'd3},
        // R1 R9: id entry with junk high bytes
        '{17'h05555, 16'h12AA, 3'd0, 4'h0, 1'b0, 4'd1},
        '{17'h02AAA, 16'h3455, 3'd0, 4'h0, 1'b0, 4'd1},
        '{17'h05555, 16'h5690, 3'd5, 4'h0, 1'b0, 4'd9},
        // R9: single-write exit anywhere
        '{17'h1ABCD, 16'h00F0, 3'd6, 4'h0, 1'b0, 4'd9},
        // R9: three-write exit
        '{17'h05555, 16'h00AA, 3'd0, 4'h0, 1'b0, 4'd9},
        '{17'h02AAA, 16'h0055, 3'd0, 4'h0, 1'b0, 4'd9},
        '{17'h05555, 16'h00F0, 3'd6, 4'h0, 1'b0, 4'd9},
        // R4: chip erase
        '{17'h05555, 16'h00AA, 3'd0, 4'h0, 1'b0, 4'd4},
        '{17'h02AAA, 16'h0055, 3'd0, 4'h0, 1'b0, 4'd4},
        '{17'h05555, 16'h0080, 3'd0, 4'h0, 1'b0, 4'd4},
        '{17'h05555, 16'h00AA, 3'd0, 4'h0, 1'b0, 4'd4},
        '{17'h02AAA, 16'h0055, 3'd0, 4'h0, 1'b0, 4'd4},
        '{17'h05555, 16'h0010, 3'd1, 4'h0, 1'b0, 4'd4},
        // R7: main region unlocked includes boot
        '{17'h05555, 16'h00AA, 3'd0, 4'h0, 1'b0, 4'd7},
        '{17'h02AAA, 16'h0055, 3'd0, 4'h0, 1'b0, 4'd7},
        '{17'h05555, 16'h0080, 3'd0, 4'h0, 1'b0, 4'd7},
        '{17'h05555, 16'h00AA, 3'd0, 4'h0, 1'b0, 4'd7},
        '{17'h02AAA, 16'h0055, 3'd0, 4'h0, 1'b0, 4'd7},
        '{17'h1F000, 16'h0030, 3'd2, 4'h9, 1'b0, 4'd7},
        // R5: parameter block 1
        '{17'h05555, 16'h00AA, 3'd0, 4'h0, 1'b0, 4'd5},
        '{17'h02AAA, 16'h0055, 3'd0, 4'h0, 1'b0, 4'd5},
        '{17'h05555, 16'h0080, 3'd0, 4'h0, 1'b0, 4'd5},
        '{17'h05555, 16'h00AA, 3'd0, 4'h0, 1'b0, 4'd5},
        '{17'h02AAA, 16'h0055, 3'd0, 4'h0, 1'b0, 4'd5},
        '{17'h03456, 16'h0030, 3'd2, 4'h2, 1'b0, 4'd5},
        // R5: parameter block 2
        '{17'h05555, 16'h00AA, 3'd0, 4'h0, 1'b0, 4'd5},
        '{17'h02AAA, 16'h0055, 3'd0, 4'h0, 1'b0, 4'd5},
        '{17'h05555, 16'h0080, 3'd0, 4'h0, 1'b0, 4'd5},
        '{17'h05555, 16'h00AA, 3'd0, 4'h0, 1'b0, 4'd5},
        '{17'h02AAA, 16'h0055, 3'd0, 4'h0, 1'b0, 4'd5},
        '{17'h05FFF, 16'h0030, 3'd2, 4'h4, 1'b0, 4'd5},
        // R10: broken second step, then stray writes
        '{17'h05555, 16'h00AA, 3'd0, 4'h0, 1'b0, 4'd10},
        '{17'h02AAA, 16'h0056, 3'd0, 4'h0, 1'b0, 4'd10},
        '{17'h05555, 16'h00A0, 3'd0, 4'h0, 1'b0, 4'd10},
        '{17'h00000, 16'h1234, 3'd0, 4'h0, 1'b0, 4'd10},
        // R2: upper address bits ignored in unlock steps
        '{17'h1D555, 16'h00AA, 3'd0, 4'h0, 1'b0, 4'd2},
        '{17'h0AAAA, 16'h0055, 3'd0, 4'h0, 1'b0, 4'd2},
        '{17'h15555, 16'h00A0, 3'd0, 4'h0, 1'b0, 4'd2},
        '{17'h1C000, 16'h5A5A, 3'd3, 4'h0, 1'b0, 4'd2},
        // R6: protection command
        '{17'h05555, 16'h00AA, 3'd0, 4'h0, 1'b0, 4'd6},
        '{17'h02AAA, 16'h0055, 3'd0, 4'h0, 1'b0, 4'd6},
        '{17'h05555, 16'h0080, 3'd0, 4'h0, 1'b0, 4'd6},
        '{17'h05555, 16'h00AA, 3'd0, 4'h0, 1'b0, 4'd6},
        '{17'h02AAA, 16'h0055, 3'd0, 4'h0, 1'b0, 4'd6},
        '{17'h05555, 16'h0040, 3'd4, 4'h0, 1'b1, 4'd6},
        // R7: main region once locked
        '{17'h05555, 16'h00AA, 3'd0, 4'h0, 1'b1, 4'd7},
        '{17'h02AAA, 16'h0055, 3'd0, 4'h0, 1'b1, 4'd7},
        '{17'h05555, 16'h0080, 3'd0, 4'h0, 1'b1, 4'd7},
        '{17'h05555, 16'h00AA, 3'd0, 4'h0, 1'b1, 4'd7},
        '{17'h02AAA, 16'h0055, 3'd0, 4'h0, 1'b1, 4'd7},
        '{17'h1F123, 16'h0030, 3'd2, 4'h8, 1'b1, 4'd7},
        // R8: boot program dropped
        '{17'h05555, 16'h00AA, 3'd0, 4'h0, 1'b1, 4'd8},
        '{17'h02AAA, 16'h0055, 3'd0, 4'h0, 1'b1, 4'd8},
        '{17'h05555, 16'h00A0, 3'd0, 4'h0, 1'b1, 4'd8},
        '{17'h01FFF, 16'hBEEF, 3'd0, 4'h0, 1'b1, 4'd8},
        // R8: first word above boot still programs
        '{17'h05555, 16'h00AA, 3'd0, 4'h0, 1'b1, 4'd8},
        '{17'h02AAA, 16'h0055, 3'd0, 4'h0, 1'b1, 4'd8},
        '{17'h05555, 16'h00A0, 3'd0, 4'h0, 1'b1, 4'd8},
        '{17'h02000, 16'hC0DE, 3'd3, 4'h0, 1'b1, 4'd8}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_ce_n = 1'b1, bus_we_n = 1'b1, bus_oe_n = 1'b1, pwr_ok = 1'b1;
    logic [16:0] bus_addr = '0;
    logic [15:0] bus_data = '0;
    logic        chip_erase_o, sector_erase_o, program_o, lockout_o;
    logic        id_enter_o, id_exit_o, boot_locked_o;
    logic [3:0]  erase_mask_o;
    logic [16:0] program_addr_o;
    logic [15:0] program_data_o;

    int errors = 0;
    int checks = 0;

    flash_cmd_decoder uut (
        .clk(clk), .rst_n(rst_n), .bus_ce_n(bus_ce_n), .bus_we_n(bus_we_n),
        .bus_oe_n(bus_oe_n), .pwr_ok(pwr_ok), .bus_addr(bus_addr), .bus_data(bus_data),
        .chip_erase_o(chip_erase_o), .sector_erase_o(sector_erase_o),
        .erase_mask_o(erase_mask_o), .program_o(program_o),
        .program_addr_o(program_addr_o), .program_data_o(program_data_o),
        .lockout_o(lockout_o), .id_enter_o(id_enter_o), .id_exit_o(id_exit_o),
        .boot_locked_o(boot_locked_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [2:0] obs_code();
        int n;
        n = int'(chip_erase_o) + int'(sector_erase_o) + int'(program_o) + int'(lockout_o)
          + int'(id_enter_o) + int'(id_exit_o);
        if (n > 1)          return 3'd7;
        if (chip_erase_o)   return 3'd1;
        if (sector_erase_o) return 3'd2;
        if (program_o)      return 3'd3;
        if (lockout_o)      return 3'd4;
        if (id_enter_o)     return 3'd5;
        if (id_exit_o)      return 3'd6;
        return 3'd0;
    endfunction

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one write pulse; outputs sampled in the cycle after the accepting edge
    logic [2:0] s_code;
    logic [3:0] s_mask;
    logic       s_lk;
    task automatic do_wr(input logic [16:0] a, input logic [15:0] d,
                         input logic oe_n, input logic ce_n, input logic pg);
        @(negedge clk);
        bus_addr = a; bus_data = d; bus_oe_n = oe_n; bus_ce_n = ce_n; pwr_ok = pg; bus_we_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        s_code = obs_code(); s_mask = erase_mask_o; s_lk = boot_locked_o;
        bus_we_n = 1'b1; bus_ce_n = 1'b1; bus_oe_n = 1'b1; pwr_ok = 1'b1;
        @(posedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12 R6: reset state
        chk(obs_code() == 3'd0 && erase_mask_o == 4'h0 && !boot_locked_o && program_addr_o == '0,
            "R12 reset outputs", {obs_code(), erase_mask_o, boot_locked_o}, 64'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            do_wr(VEC[i].a, VEC[i].d, 1'b1, 1'b0, 1'b1);
            chk(s_code == VEC[i].code && s_mask == VEC[i].mask && s_lk == VEC[i].lk,
                $sformatf("R%0d vector %0d", VEC[i].rq, i),
                {s_code, s_mask, s_lk}, {VEC[i].code, VEC[i].mask, VEC[i].lk});
            if (VEC[i].code == 3'd3)
                // R3 R1: program address and full data word
                chk(program_addr_o == VEC[i].a && program_data_o == VEC[i].d,
                    $sformatf("R3 program payload %0d", i),
                    {program_addr_o, program_data_o}, {VEC[i].a, VEC[i].d});
        end

        // R5: unlisted region code gives no strobe
        do_wr(17'h05555, 16'h00AA, 1'b1, 1'b0, 1'b1);
        do_wr(17'h02AAA, 16'h0055, 1'b1, 1'b0, 1'b1);
        do_wr(17'h05555, 16'h0080, 1'b1, 1'b0, 1'b1);
        do_wr(17'h05555, 16'h00AA, 1'b1, 1'b0, 1'b1);
        do_wr(17'h02AAA, 16'h0055, 1'b1, 1'b0, 1'b1);
        do_wr(17'h0A000, 16'h0030, 1'b1, 1'b0, 1'b1);
        chk(s_code == 3'd0 && s_mask == 4'h0, "R5 bad region", {s_code, s_mask}, 64'h0);

        // R11: inhibited single-write exits
        do_wr(17'h00000, 16'h00F0, 1'b0, 1'b0, 1'b1);
        chk(s_code == 3'd0, "R11 oe low", s_code, 0);
        do_wr(17'h00000, 16'h00F0, 1'b1, 1'b1, 1'b1);
        chk(s_code == 3'd0, "R11 ce high", s_code, 0);
        do_wr(17'h00000, 16'h00F0, 1'b1, 1'b0, 1'b0);
        chk(s_code == 3'd0, "R11 power low", s_code, 0);

        // R11: inhibited final write keeps the program sequence open
        do_wr(17'h05555, 16'h00AA, 1'b1, 1'b0, 1'b1);
        do_wr(17'h02AAA, 16'h0055, 1'b1, 1'b0, 1'b1);
        do_wr(17'h05555, 16'h00A0, 1'b1, 1'b0, 1'b1);
        do_wr(17'h03000, 16'h1111, 1'b0, 1'b0, 1'b1);
        chk(s_code == 3'd0, "R11 inhibited final write", s_code, 0);
        do_wr(17'h03000, 16'h7777, 1'b1, 1'b0, 1'b1);
        chk(s_code == 3'd3 && program_addr_o == 17'h03000 && program_data_o == 16'h7777,
            "R11 sequence resumes", {s_code, program_addr_o, program_data_o},
            {3'd3, 17'h03000, 16'h7777});

        // R12: write enable held low for several cycles gives one exit pulse
        @(negedge clk);
        bus_addr = 17'h00042; bus_data = 16'h00F0; bus_ce_n = 1'b0; bus_we_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(obs_code() == 3'd6, "R12 first cycle", obs_code(), 6);
        @(posedge clk);
        @(negedge clk);
        chk(obs_code() == 3'd0, "R12 held cycle 2", obs_code(), 0);
        @(posedge clk);
        @(negedge clk);
        chk(obs_code() == 3'd0, "R12 held cycle 3", obs_code(), 0);
        bus_we_n = 1'b1; bus_ce_n = 1'b1;

        // R6: flag survives until reset, then clears
        chk(boot_locked_o == 1'b1, "R6 still locked", boot_locked_o, 1);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(boot_locked_o == 1'b0 && obs_code() == 3'd0, "R6 reset clears flag",
            {boot_locked_o, obs_code()}, 0);
        rst_n = 1'b1;

        // R8: boot program allowed again after reset
        do_wr(17'h05555, 16'h00AA, 1'b1, 1'b0, 1'b1);
        do_wr(17'h02AAA, 16'h0055, 1'b1, 1'b0, 1'b1);
        do_wr(17'h05555, 16'h00A0, 1'b1, 1'b0, 1'b1);
        do_wr(17'h01FFF, 16'hBEEF, 1'b1, 1'b0, 1'b1);
        chk(s_code == 3'd3 && program_addr_o == 17'h01FFF, "R8 boot open",
            {s_code, program_addr_o}, {3'd3, 17'h01FFF});

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule